// File: doc/BRIEF.md
# Stack Pointer and Call/Return Sequencer

This block holds a processor's stack pointer and turns stack-related requests into a cycle-by-cycle sequence of memory transfers. It handles six stack operations: pushing a data word, popping a data word, a subroutine call, a subroutine return, an interrupt entry and a return from interrupt. It also handles a seventh request that loads the pointer directly. The stack grows downward in word steps of two bytes. The pointer is kept word-aligned at all times. Addresses, write data and strobes go to a memory with one cycle of read latency: a word read in cycle N appears on `mem_rdata` in cycle N+1.

The request is a 3-bit code on `req_op`, and code 0 means no request. The block samples a request only on a clock edge where `busy` is low. A request presented while `busy` is high is dropped. The caller therefore holds off new work until `busy` clears. Recovered program counters, a restored status word and popped data words leave on their own outputs, each with a one-cycle valid strobe.

Top module: `stk_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `sp` equals `SP_RESET` (default 0x0400), and `busy`, `mem_we`, `mem_re`, `pc_valid`, `sr_valid` and `pop_valid` are all low.
- R2: Code 7 (pointer load) sets `sp` to `target` with bit 0 cleared, starting in the cycle after acceptance. It does not raise `busy`. The value of `sp` is even in every cycle.
- R3: Code 1 (push) first lowers `sp` by 2. In the next cycle it raises `mem_we` for one cycle, with `mem_addr` equal to the new `sp` and `mem_wdata` equal to `push_data`.
- R4: Code 2 (pop) produces a read strobe at the current `sp` in the cycle after acceptance. One cycle later it raises `pop_valid` with the word read, and `sp` is then 2 higher.
- R5: Code 3 (call) writes `pc_in` at the old `sp` minus 2 in the cycle after acceptance. In that same cycle `pc_out` equals `target` and `pc_valid` is high.
- R6: Code 4 (return) reads at `sp`. In the following cycle `pc_out` carries the word read, `pc_valid` is high and `sp` has risen by 2.
- R7: Code 5 (interrupt entry) performs two writes on consecutive cycles: `pc_in` at S-2, then `sr_in` at S-4, where S is `sp` before the request. In the second write cycle `pc_out` equals `target` (the vector) with `pc_valid` high. Afterwards `sp` is S-4.
- R8: Code 6 (return from interrupt) reads the status word at S and then the program counter at S+2. It raises `sr_valid` with the first word and then `pc_valid` with the second, one cycle apart. Afterwards `sp` is S+4.
- R9: A nonzero code presented while `busy` is high has no effect: `sp`, the memory strobes and the valid strobes follow only the operation already in progress.
- R10: `mem_we` and `mem_re` are never high together. `pc_valid`, `sr_valid` and `pop_valid` never stay high for two consecutive cycles. With no request, all strobes stay low.
- R11: With `PC_ALIGN`=1, a program counter taken from memory by return or return from interrupt leaves on `pc_out` with bit 0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_op | input | 3 | Request code (0 none, 1 push, 2 pop, 3 call, 4 return, 5 interrupt entry, 6 return from interrupt, 7 pointer load) |
| pc_in | input | AW | Current program counter, stored by call and interrupt entry |
| sr_in | input | DW | Current status word, stored by interrupt entry |
| push_data | input | DW | Word stored by push |
| target | input | AW | Call target, interrupt vector or new pointer value |
| mem_rdata | input | DW | Read data, valid one cycle after a read strobe |
| mem_addr | output | AW | Memory address, equal to the stack pointer |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| pc_out | output | AW | New program counter |
| pc_valid | output | 1 | One-cycle strobe for `pc_out` |
| sr_out | output | DW | Restored status word |
| sr_valid | output | 1 | One-cycle strobe for `sr_out` |
| pop_data | output | DW | Word returned by pop |
| pop_valid | output | 1 | One-cycle strobe for `pop_data` |
| busy | output | 1 | High while a sequence is in progress; requests are ignored |
| sp | output | AW | Current stack pointer |

## Verification
The hardest situation to reach is a request that arrives in the middle of a sequence. The worst case is inside the three-cycle return from interrupt, where the second read is issued in the same cycle as the first word is returned, and a dropped request must not change the pointer. The stimulus sends requests on every cycle without waiting for `busy`, so each multi-word sequence is hit by colliding requests at every stage. A return from interrupt directly after an interrupt entry shows that the two status and counter words come back in the reverse of the order they were written. A pointer load to zero followed by a push makes the decrement wrap to the top of the address space.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_PUSH = 3'd1,
      OP_POP  = 3'd2,
      OP_CALL = 3'd3,
      OP_RET  = 3'd4,
      OP_IENT = 3'd5,
      OP_IRET = 3'd6,
      OP_SPLD = 3'd7
   } stk_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR_FIRST,
      ST_WR_LAST,
      ST_RD_REQ,
      ST_RD_SR,
      ST_RD_DATA
   } seq_st_e;

   typedef enum logic [1:0] {
      SP_HOLD,
      SP_DEC,
      SP_INC,
      SP_LOAD
   } sp_cmd_e;

   typedef enum logic [1:0] {
      RK_POP,
      RK_RET,
      RK_IRET
   } rd_kind_e;

endpackage

// File: rtl/stk_sp_reg.sv
module stk_sp_reg
   import stk_pkg::*;
#(
   parameter int          AW       = 16,
   parameter logic [AW-1:0] SP_RESET = 16'h0400
) (
   input  logic          clk,
   input  logic          rst_n,
   input  sp_cmd_e       cmd,
   input  logic [AW-2:0] load_hi,
   output logic [AW-1:0] sp
);
   // only the word index is stored; bit 0 is a constant zero
   localparam logic [AW-2:0] HI_RESET = SP_RESET[AW-1:1];
   localparam logic [AW-2:0] HI_STEP  = {{(AW-2){1'b0}}, 1'b1};

   logic [AW-2:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= HI_RESET;
      end else begin
         case (cmd)
            SP_DEC:  hi_q <= hi_q - HI_STEP;
            SP_INC:  hi_q <= hi_q + HI_STEP;
            SP_LOAD: hi_q <= load_hi;
            default: hi_q <= hi_q;
         endcase
      end
   end

   assign sp = {hi_q, 1'b0};

endmodule

// File: rtl/stk_fsm.sv
module stk_fsm
   import stk_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    req_op,
   input  logic [AW-1:0] pc_in,
   input  logic [DW-1:0] sr_in,
   input  logic [DW-1:0] push_data,
   input  logic [AW-1:0] target,
   output sp_cmd_e       sp_cmd,
   output logic [DW-1:0] wdata,
   output logic [AW-1:0] tgt,
   output logic          mem_we,
   output logic          mem_re,
   output logic          sel_tgt,
   output logic          pc_valid,
   output logic          sr_valid,
   output logic          pop_valid,
   output logic          busy
);
   seq_st_e       st_q, st_nx;
   rd_kind_e      kind_q;
   logic          call_q;
   logic [DW-1:0] wd_q, wd2_q;
   logic [AW-1:0] tgt_q;
   stk_op_e       op;
   logic [DW-1:0] pc_ext;

   assign op     = stk_op_e'(req_op);
   assign pc_ext = DW'(pc_in);

   // next state and pointer command
   always_comb begin
      st_nx  = st_q;
      sp_cmd = SP_HOLD;
      case (st_q)
         ST_IDLE: begin
            case (op)
               OP_PUSH, OP_CALL: begin
                  sp_cmd = SP_DEC;
                  st_nx  = ST_WR_LAST;
               end
               OP_IENT: begin
                  sp_cmd = SP_DEC;
                  st_nx  = ST_WR_FIRST;
               end
               OP_POP, OP_RET, OP_IRET: st_nx = ST_RD_REQ;
               OP_SPLD: sp_cmd = SP_LOAD;
               default: st_nx = ST_IDLE;
            endcase
         end
         ST_WR_FIRST: begin
            sp_cmd = SP_DEC;
            st_nx  = ST_WR_LAST;
         end
         ST_WR_LAST: st_nx = ST_IDLE;
         ST_RD_REQ: begin
            sp_cmd = SP_INC;
            st_nx  = (kind_q == RK_IRET) ? ST_RD_SR : ST_RD_DATA;
         end
         ST_RD_SR: begin
            sp_cmd = SP_INC;
            st_nx  = ST_RD_DATA;
         end
         ST_RD_DATA: st_nx = ST_IDLE;
         default:    st_nx = ST_IDLE;
      endcase
   end

   // state and captured operands
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         kind_q <= RK_POP;
         call_q <= 1'b0;
         wd_q   <= '0;
         wd2_q  <= '0;
         tgt_q  <= '0;
      end else begin
         st_q <= st_nx;
         case (st_q)
            ST_IDLE: begin
               case (op)
                  OP_PUSH: begin
                     wd_q   <= push_data;
                     call_q <= 1'b0;
                  end
                  OP_CALL: begin
                     wd_q   <= pc_ext;
                     tgt_q  <= target;
                     call_q <= 1'b1;
                  end
                  OP_IENT: begin
                     wd_q   <= pc_ext;
                     wd2_q  <= sr_in;
                     tgt_q  <= target;
                     call_q <= 1'b0;
                  end
                  OP_POP:  kind_q <= RK_POP;
                  OP_RET:  kind_q <= RK_RET;
                  OP_IRET: kind_q <= RK_IRET;
                  default: call_q <= call_q;
               endcase
            end
            ST_WR_FIRST: begin
               wd_q   <= wd2_q;
               call_q <= 1'b1;
            end
            ST_RD_SR: kind_q <= RK_RET;
            default:  call_q <= call_q;
         endcase
      end
   end

   assign wdata     = wd_q;
   assign tgt       = tgt_q;
   assign busy      = (st_q != ST_IDLE);
   assign mem_we    = (st_q == ST_WR_FIRST) || (st_q == ST_WR_LAST);
   assign mem_re    = (st_q == ST_RD_REQ) || (st_q == ST_RD_SR);
   assign sel_tgt   = (st_q == ST_WR_LAST);
   assign pc_valid  = ((st_q == ST_WR_LAST) && call_q) ||
                      ((st_q == ST_RD_DATA) && (kind_q == RK_RET));
   assign sr_valid  = (st_q == ST_RD_SR);
   assign pop_valid = (st_q == ST_RD_DATA) && (kind_q == RK_POP);

endmodule

// File: rtl/stk_outmux.sv
module stk_outmux #(
   parameter int AW       = 16,
   parameter int DW       = 16,
   parameter bit PC_ALIGN = 1'b1
) (
   input  logic [DW-1:0] rdata,
   input  logic [AW-1:0] tgt,
   input  logic          sel_tgt,
   output logic [AW-1:0] pc_out,
   output logic [DW-1:0] sr_out,
   output logic [DW-1:0] pop_data
);
   logic [AW-1:0] pc_mem;

   generate
      if (PC_ALIGN) begin : g_align
         assign pc_mem = {rdata[AW-1:1], 1'b0};
      end else begin : g_raw
         assign pc_mem = rdata[AW-1:0];
      end
   endgenerate

   assign pc_out   = sel_tgt ? tgt : pc_mem;
   assign sr_out   = rdata;
   assign pop_data = rdata;

endmodule

// File: rtl/stk_seq.sv
module stk_seq
   import stk_pkg::*;
#(
   parameter int            AW       = 16,
   parameter int            DW       = 16,
   parameter logic [AW-1:0] SP_RESET = 16'h0400,
   parameter bit            PC_ALIGN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    req_op,
   input  logic [AW-1:0] pc_in,
   input  logic [DW-1:0] sr_in,
   input  logic [DW-1:0] push_data,
   input  logic [AW-1:0] target,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_we,
   output logic          mem_re,
   output logic [AW-1:0] pc_out,
   output logic          pc_valid,
   output logic [DW-1:0] sr_out,
   output logic          sr_valid,
   output logic [DW-1:0] pop_data,
   output logic          pop_valid,
   output logic          busy,
   output logic [AW-1:0] sp
);
   generate
      if (AW < 2) begin : g_bad_aw
         $error("stk_seq: AW must be at least 2");
      end
      if (DW < AW) begin : g_bad_dw
         $error("stk_seq: DW must hold a full program counter");
      end
      if (SP_RESET[0] != 1'b0) begin : g_bad_rst
         $error("stk_seq: SP_RESET must be even");
      end
   endgenerate

   sp_cmd_e       sp_cmd;
   logic [AW-1:0] tgt;
   logic          sel_tgt;

   stk_fsm #(.AW(AW), .DW(DW)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_op    (req_op),
      .pc_in     (pc_in),
      .sr_in     (sr_in),
      .push_data (push_data),
      .target    (target),
      .sp_cmd    (sp_cmd),
      .wdata     (mem_wdata),
      .tgt       (tgt),
      .mem_we    (mem_we),
      .mem_re    (mem_re),
      .sel_tgt   (sel_tgt),
      .pc_valid  (pc_valid),
      .sr_valid  (sr_valid),
      .pop_valid (pop_valid),
      .busy      (busy)
   );

   stk_sp_reg #(.AW(AW), .SP_RESET(SP_RESET)) u_sp (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (sp_cmd),
      .load_hi (target[AW-1:1]),
      .sp      (sp)
   );

   stk_outmux #(.AW(AW), .DW(DW), .PC_ALIGN(PC_ALIGN)) u_mux (
      .rdata    (mem_rdata),
      .tgt      (tgt),
      .sel_tgt  (sel_tgt),
      .pc_out   (pc_out),
      .sr_out   (sr_out),
      .pop_data (pop_data)
   );

   assign mem_addr = sp;

endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    req_op,
   input logic [AW-1:0] target,
   input logic          busy,
   input logic [AW-1:0] sp,
   input logic          mem_we,
   input logic          mem_re,
   input logic          pc_valid,
   input logic          sr_valid,
   input logic          pop_valid
);
   localparam logic [AW-1:0] TWO = AW'(2);
   localparam logic [AW-1:0] EVN = ~AW'(1);

   // R2: pointer load lands the even form of the target
   a_r2_load_even: assert property (@(posedge clk) disable iff (!rst_n)
      (req_op == 3'd7 && !busy) |=> (sp == ($past(target) & EVN)));

   // R3: the first write of a sequence follows a decrement by 2
   a_r3_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !$past(mem_we)) |-> (sp == $past(sp) - TWO));

   // R7: the second consecutive write sits 2 lower and carries the vector strobe
   a_r7_second_write: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (pc_valid && sp == $past(sp) - TWO));

   // R4: popped data follows a read strobe
   a_r4_pop_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid |-> ($past(mem_re) && !mem_re && sp == $past(sp) + TWO));

   // R6: a counter from memory follows a read and a raise by 2
   a_r6_ret_read: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_valid && !mem_we) |-> ($past(mem_re) && sp == $past(sp) + TWO));

   // R8: status comes back one cycle before the counter
   a_r8_sr_then_pc: assert property (@(posedge clk) disable iff (!rst_n)
      sr_valid |=> pc_valid);

   // R10: strobe exclusivity and single-cycle valids
   a_r10_we_re_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   a_r10_pc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pc_valid |=> !pc_valid);

   a_r10_valid_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pc_valid, sr_valid, pop_valid}));

endmodule

bind stk_seq stk_seq_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_op    (req_op),
   .target    (target),
   .busy      (busy),
   .sp        (sp),
   .mem_we    (mem_we),
   .mem_re    (mem_re),
   .pc_valid  (pc_valid),
   .sr_valid  (sr_valid),
   .pop_valid (pop_valid)
);

// File: tb/stk_seq_tb_top.sv
module stk_seq_tb_top;

   localparam int          CLK_PERIOD = 10;
   localparam int          AW         = 16;
   localparam int          DW         = 16;
   localparam logic [15:0] SP_INIT    = 16'h0400;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    req_op = '0;
   logic [AW-1:0] pc_in = '0;
   logic [DW-1:0] sr_in = '0;
   logic [DW-1:0] push_data = '0;
   logic [AW-1:0] target = '0;
   logic [DW-1:0] mem_rdata = '0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_we, mem_re;
   logic [AW-1:0] pc_out;
   logic          pc_valid;
   logic [DW-1:0] sr_out;
   logic          sr_valid;
   logic [DW-1:0] pop_data;
   logic          pop_valid;
   logic          busy;
   logic [AW-1:0] sp;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stk_seq #(.AW(AW), .DW(DW), .SP_RESET(SP_INIT), .PC_ALIGN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_op(req_op), .pc_in(pc_in), .sr_in(sr_in),
      .push_data(push_data), .target(target), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
      .pc_out(pc_out), .pc_valid(pc_valid), .sr_out(sr_out), .sr_valid(sr_valid),
      .pop_data(pop_data), .pop_valid(pop_valid), .busy(busy), .sp(sp)
   );

   // memory with one cycle of read latency
   logic [15:0] bmem [int];
   always @(posedge clk) begin
      if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
      if (mem_re) mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 16'h0000;
   end

   // reference model state
   typedef struct {
      bit          busy, we, re, pcv, srv, popv;
      logic [15:0] addr, wd, pc, sr, pop, sp;
      string       tag;
   } exp_t;

   exp_t        q[$];
   logic [15:0] rmem [int];
   logic [15:0] ref_sp;

   function automatic logic [15:0] rrd(input logic [15:0] a);
      return rmem.exists(int'(a)) ? rmem[int'(a)] : 16'h0000;
   endfunction

   function automatic exp_t blank(input string t, input bit b);
      exp_t e;
      e.busy = b; e.we = 0; e.re = 0; e.pcv = 0; e.srv = 0; e.popv = 0;
      e.addr = 0; e.wd = 0; e.pc = 0; e.sr = 0; e.pop = 0; e.sp = ref_sp;
      e.tag = t;
      return e;
   endfunction

   task automatic chk(input string t, input string nm, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", t, nm, act, exp, $time);
      end
   endtask

   task automatic compare(input exp_t e);
      chk(e.tag, "busy", 16'(busy), 16'(e.busy));
      chk(e.tag, "sp", sp, e.sp);
      chk(e.tag, "mem_we", 16'(mem_we), 16'(e.we));
      chk(e.tag, "mem_re", 16'(mem_re), 16'(e.re));
      chk(e.tag, "pc_valid", 16'(pc_valid), 16'(e.pcv));
      chk(e.tag, "sr_valid", 16'(sr_valid), 16'(e.srv));
      chk(e.tag, "pop_valid", 16'(pop_valid), 16'(e.popv));
      if (e.we || e.re) chk(e.tag, "mem_addr", mem_addr, e.addr);
      if (e.we)   chk(e.tag, "mem_wdata", mem_wdata, e.wd);
      if (e.pcv)  chk(e.tag, "pc_out", pc_out, e.pc);
      if (e.srv)  chk(e.tag, "sr_out", sr_out, e.sr);
      if (e.popv) chk(e.tag, "pop_data", pop_data, e.pop);
   endtask

   // one clock: check this cycle, then drive a request and predict its effect
   task automatic cyc(input logic [2:0] op, input logic [15:0] pc, input logic [15:0] sr,
                      input logic [15:0] d, input logic [15:0] tg);
      exp_t e, n;
      logic [15:0] s;
      @(negedge clk);
      if (q.size() > 0) e = q.pop_front();
      else e = blank("R10", 1'b0);
      compare(e);
      req_op = op; pc_in = pc; sr_in = sr; push_data = d; target = tg;
      if (op == 3'd0) return;
      if (e.busy) begin
         // R9: dropped request, the in-flight sequence continues unchanged
         if (q.size() > 0) q[0].tag = {q[0].tag, " R9"};
         else q.push_back(blank("R9", 1'b0));
         return;
      end
      s = ref_sp;
      case (op)
         3'd1, 3'd3: begin
            n = blank((op == 3'd1) ? "R3" : "R5", 1'b1);
            n.we = 1; n.addr = s - 16'd2; n.sp = s - 16'd2;
            n.wd = (op == 3'd1) ? d : pc;
            if (op == 3'd3) begin n.pcv = 1; n.pc = tg; end
            rmem[int'(n.addr)] = n.wd;
            q.push_back(n);
            ref_sp = s - 16'd2;
         end
         3'd5: begin
            n = blank("R7", 1'b1);
            n.we = 1; n.addr = s - 16'd2; n.sp = s - 16'd2; n.wd = pc;
            rmem[int'(n.addr)] = pc;
            q.push_back(n);
            n = blank("R7", 1'b1);
            n.we = 1; n.addr = s - 16'd4; n.sp = s - 16'd4; n.wd = sr;
            n.pcv = 1; n.pc = tg;
            rmem[int'(n.addr)] = sr;
            q.push_back(n);
            ref_sp = s - 16'd4;
         end
         3'd2, 3'd4: begin
            n = blank((op == 3'd2) ? "R4" : "R6/R11", 1'b1);
            n.re = 1; n.addr = s; n.sp = s;
            q.push_back(n);
            n = blank((op == 3'd2) ? "R4" : "R6/R11", 1'b1);
            n.sp = s + 16'd2;
            if (op == 3'd2) begin n.popv = 1; n.pop = rrd(s); end
            else begin n.pcv = 1; n.pc = rrd(s) & 16'hFFFE; end
            q.push_back(n);
            ref_sp = s + 16'd2;
         end
         3'd6: begin
            n = blank("R8", 1'b1);
            n.re = 1; n.addr = s; n.sp = s;
            q.push_back(n);
            n = blank("R8", 1'b1);
            n.re = 1; n.addr = s + 16'd2; n.sp = s + 16'd2;
            n.srv = 1; n.sr = rrd(s);
            q.push_back(n);
            n = blank("R8/R11", 1'b1);
            n.sp = s + 16'd4; n.pcv = 1; n.pc = rrd(s + 16'd2) & 16'hFFFE;
            q.push_back(n);
            ref_sp = s + 16'd4;
         end
         default: begin
            ref_sp = tg & 16'hFFFE;
            q.push_back(blank("R2", 1'b0));
         end
      endcase
   endtask

   initial begin
      ref_sp = SP_INIT;
      repeat (3) @(negedge clk);
      // R1: reset values while reset is held
      chk("R1", "sp", sp, SP_INIT);
      chk("R1", "busy", 16'(busy), 16'd0);
      chk("R1", "strobes", 16'({mem_we, mem_re, pc_valid, sr_valid, pop_valid}), 16'd0);
      rst_n = 1'b1;
      cyc(3'd0, 0, 0, 0, 0);
      cyc(3'd0, 0, 0, 0, 0);
      // R2: odd load target comes out even
      cyc(3'd7, 0, 0, 0, 16'h0301);
      cyc(3'd0, 0, 0, 0, 0);
      // R3/R9: back-to-back pushes, every other one collides with busy
      cyc(3'd1, 0, 0, 16'hA1A1, 0);
      cyc(3'd1, 0, 0, 16'hFFFF, 0);
      cyc(3'd1, 0, 0, 16'hB2B2, 0);
      cyc(3'd7, 0, 0, 0, 16'h0100);
      // R4: LIFO pops with colliding requests
      cyc(3'd2, 0, 0, 0, 0);
      cyc(3'd1, 0, 0, 16'hDEAD, 0);
      cyc(3'd7, 0, 0, 0, 16'h0010);
      cyc(3'd2, 0, 0, 0, 0);
      cyc(3'd0, 0, 0, 0, 0);
      cyc(3'd0, 0, 0, 0, 0);
      // R11: odd word returned as a counter
      cyc(3'd1, 0, 0, 16'h1235, 0);
      cyc(3'd0, 0, 0, 0, 0);
      cyc(3'd4, 0, 0, 0, 0);
      cyc(3'd0, 0, 0, 0, 0);
      cyc(3'd0, 0, 0, 0, 0);
      // R5/R6: call then return
      cyc(3'd3, 16'h2222, 0, 0, 16'h4000);
      cyc(3'd0, 0, 0, 0, 0);
      cyc(3'd4, 0, 0, 0, 0);
      cyc(3'd0, 0, 0, 0, 0);
      cyc(3'd0, 0, 0, 0, 0);
      // R7/R8: interrupt entry and return, requests fired into every stage
      cyc(3'd5, 16'h3334, 16'h0008, 0, 16'hFFE0);
      cyc(3'd2, 0, 0, 0, 0);
      cyc(3'd7, 0, 0, 0, 16'h0000);
      cyc(3'd6, 0, 0, 0, 0);
      cyc(3'd1, 0, 0, 16'h5555, 0);
      cyc(3'd5, 16'h7777, 16'h1111, 0, 16'h8000);
      cyc(3'd7, 0, 0, 0, 16'h0002);
      cyc(3'd0, 0, 0, 0, 0);
      // nested: call inside an interrupt, unwound in reverse
      cyc(3'd5, 16'h0A0A, 16'h00F0, 0, 16'hFFF0);
      cyc(3'd0, 0, 0, 0, 0);
      cyc(3'd0, 0, 0, 0, 0);
      cyc(3'd3, 16'h0B0B, 0, 0, 16'h6000);
      cyc(3'd0, 0, 0, 0, 0);
      cyc(3'd4, 0, 0, 0, 0);
      cyc(3'd0, 0, 0, 0, 0);
      cyc(3'd0, 0, 0, 0, 0);
      cyc(3'd6, 0, 0, 0, 0);
      cyc(3'd0, 0, 0, 0, 0);
      cyc(3'd0, 0, 0, 0, 0);
      cyc(3'd0, 0, 0, 0, 0);
      // R2/R3: wrap below address zero
      cyc(3'd7, 0, 0, 0, 16'h0001);
      cyc(3'd1, 0, 0, 16'hCAFE, 0);
      cyc(3'd0, 0, 0, 0, 0);
      cyc(3'd2, 0, 0, 0, 0);
      for (int i = 0; i < 6; i++) cyc(3'd0, 0, 0, 0, 0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule